// File: doc/BRIEF.md
# Prescaled Toggling Interrupt-Output Timer

This block derives a slow square wave from the bus clock and drives it onto an external interrupt output pin. A fixed prescaler divides the bus clock into count ticks. A reload counter then measures a programmable number of ticks. In toggle mode the output level inverts each time the programmed interval has passed. Software can measure the period of the resulting wave against a known time base and so work out the bus clock frequency. Later timing settings elsewhere in the chip are derived from that result.

Software writes one 32-bit control word. It holds the reload count, a mode field and a diagnostic bit. The same word reads back those fields and, in its top bit, the live output level. Two pin-control inputs, a direction bit and an output-enable bit, decide whether the internal level actually reaches the pin. Any write restarts the timing from zero. Writing an all-zero word parks the block in its power-on state.

Top module: `irq_out_timer`

## Requirements
- R1: One count tick lasts exactly PRESCALE bus clock cycles, with a default of 520. Ticks are counted from the clock edge that accepts a control write.
- R2: When the mode field (bits [18:16]) equals 3'b111, the output level inverts after every COUNT+1 ticks. It changes at no other time.
- R3: In toggle mode the full square-wave period is 2·(COUNT+1) ticks, which is 2·(COUNT+1)·PRESCALE cycles. Each half is equal.
- R4: The control word holds COUNT in bits [15:0], the mode in bits [18:16] and the diagnostic bit in bit 19. A write stores these fields, and they read back on rd_data from the next cycle. Bits [30:20] read as zero.
- R5: With any mode value other than 3'b111, the output level is held low and counting is stopped.
- R6: Writing the all-zero word returns the block to its reset state. rd_data reads 0 from the next cycle, and the output stays low.
- R7: Any write restarts both the prescaler and the tick counter from zero and clears the output level to low. The next toggle then comes a full COUNT+1 ticks after that write.
- R8: The live output level reads back in bit 31 of rd_data. irq_pin equals that level only when out_dir and out_en are both 1; otherwise irq_pin is 0.
- R9: The diagnostic bit is stored and read back but does not change the waveform.
- R10: After reset, rd_data is 0 and irq_pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word readback with the live level in bit 31 |
| out_dir | input | 1 | Pin-control direction bit for the interrupt output |
| out_en | input | 1 | Pin-control output enable |
| irq_pin | output | 1 | Gated interrupt output pin |

## Verification
A fault in the prescaler or the tick counter shows up as a wrong half-period. Each half-period is measured edge by edge, so the very first toggle after a write exposes an off-by-one of a single cycle. This happens within (COUNT+1)·PRESCALE cycles. A level register that fails to clear on a write, or that moves outside toggle mode, is visible in bit 31 of rd_data on the next cycle. A fault in the pin gating appears at once on irq_pin for the affected combination of direction and enable.

// File: rtl/irq_out_timer_pkg.sv
package irq_out_timer_pkg;

    localparam int CTL_W   = 32;
    localparam int COUNT_W = 16;
    localparam int MODE_W  = 3;
    localparam int LEVEL_BIT = 31;

    localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b111;

    // stored fields of the control word; order fixes bit positions [19:0]
    typedef struct packed {
        logic               diag;
        logic [MODE_W-1:0]  mode;
        logic [COUNT_W-1:0] count;
    } ctl_t;

    localparam int FIELD_W = $bits(ctl_t);
    localparam int PAD_W   = CTL_W - 1 - FIELD_W;

    function automatic logic [CTL_W-1:0] pack_rd(input ctl_t c, input logic lvl);
        return {lvl, {PAD_W{1'b0}}, c};
    endfunction

endpackage

// File: rtl/irq_out_timer_ctl.sv
module irq_out_timer_ctl
    import irq_out_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl
);
    typedef struct packed {
        ctl_t c;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.c = ctl_t'(wr_data[FIELD_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.c;
endmodule

// File: rtl/irq_out_timer_presc.sv
module irq_out_timer_presc #(
    parameter int PRESCALE = 520
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } st_t;

    st_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.pre == LAST);
        tick    = run && !restart && at_last;
        if (restart || !run) begin
            st_d.pre = '0;
        end else if (at_last) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_out_timer_reload.sv
module irq_out_timer_reload #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic          level
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || !run) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == reload) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/irq_out_timer.sv
module irq_out_timer
    import irq_out_timer_pkg::*;
#(
    parameter int PRESCALE = 520
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             out_dir,
    input  logic             out_en,
    output logic             irq_pin
);
    ctl_t ctl;
    logic run;
    logic tick;
    logic level;

    irq_out_timer_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl)
    );

    assign run = (ctl.mode == MODE_TOGGLE);

    irq_out_timer_presc #(.PRESCALE(PRESCALE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_en),
        .tick    (tick)
    );

    irq_out_timer_reload #(.CW(COUNT_W)) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_en),
        .tick    (tick),
        .reload  (ctl.count),
        .level   (level)
    );

    assign rd_data = pack_rd(ctl, level);
    assign irq_pin = level & out_dir & out_en;
endmodule

// File: rtl/irq_out_timer_chk.sv
module irq_out_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        out_dir,
    input logic        out_en,
    input logic        irq_pin,
    input logic        tick
);
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin |-> (out_dir && out_en && rd_data[31])); // R8

    AST_NONTOGGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[18:16] != 3'b111) |-> !rd_data[31]); // R5

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_data[31]); // R7

    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 32'd0) |=> (rd_data == 32'd0)); // R6

    AST_FIELDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[19:0] == $past(wr_data[19:0]) && rd_data[30:20] == 11'd0)); // R4

    AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(rd_data[31])); // R2
endmodule

bind irq_out_timer irq_out_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .out_dir (out_dir),
    .out_en  (out_en),
    .irq_pin (irq_pin),
    .tick    (tick)
);

// File: tb/irq_out_timer_tb.sv
module irq_out_timer_tb;
    localparam int P = 520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        out_dir = 1'b1;
    logic        out_en = 1'b1;
    logic        irq_pin;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_out_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .out_dir(out_dir), .out_en(out_en), .irq_pin(irq_pin)
    );

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue a write at the next edge; returns at the negedge after that edge
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // edges until bit 31 differs from its present value
    task automatic measure(output int n);
        logic start;
        start = rd_data[31];
        n = 0;
        while (n < 40000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rd_data[31] != start) return;
        end
        n = -1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(rd_data == 32'd0, "R10", rd_data, 0);
        chk(irq_pin == 1'b0, "R10", irq_pin, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'd0, "R10", rd_data, 0);

        // R1 R2 R3: sweep COUNT 0..7, three half-periods each
        for (int c = 0; c < 8; c++) begin
            wr({12'd0, 1'b0, 3'b111, 16'(c)});
            chk(rd_data == {12'd0, 1'b0, 3'b111, 16'(c)}, "R4", rd_data, {12'd0, 1'b0, 3'b111, 16'(c)});
            for (int h = 0; h < 3; h++) begin
                measure(n);
                chk(n == P * (c + 1), "R1_R3 half-period", n, P * (c + 1));
                chk(rd_data[31] == ((h % 2) == 0), "R2 level", rd_data[31], (h % 2) == 0);
            end
        end

        // R4: pad bits ignored, fields read back
        wr(32'h7FF5_1234);
        chk(rd_data == 32'h0005_1234, "R4", rd_data, 32'h0005_1234);

        // R5: non-toggle modes hold low
        for (int m = 0; m < 7; m++) begin
            wr({12'd0, 1'b0, 3'(m), 16'd0});
            repeat (2 * P + 10) begin
                @(negedge clk);
                if (rd_data[31]) break;
            end
            chk(rd_data[31] == 1'b0 && irq_pin == 1'b0, "R5", rd_data[31], 0);
        end

        // R6: zero write while level high
        wr({12'd0, 1'b0, 3'b111, 16'd0});
        measure(n);
        chk(rd_data[31] == 1'b1, "R6 precondition", rd_data[31], 1);
        wr(32'd0);
        chk(rd_data == 32'd0, "R6", rd_data, 0);
        repeat (3 * P) @(negedge clk);
        chk(rd_data == 32'd0 && irq_pin == 1'b0, "R6", rd_data, 0);

        // R7: rewrite mid-interval restarts timing
        wr({12'd0, 1'b0, 3'b111, 16'd1});
        repeat (700) @(negedge clk);
        chk(rd_data[31] == 1'b0, "R7 before toggle", rd_data[31], 0);
        wr({12'd0, 1'b0, 3'b111, 16'd1});
        measure(n);
        chk(n == 2 * P, "R7 restart", n, 2 * P);
        // rewrite while high clears level
        wr({12'd0, 1'b0, 3'b111, 16'd1});
        chk(rd_data[31] == 1'b0, "R7 clear", rd_data[31], 0);

        // R8: pin gating while level high
        wr({12'd0, 1'b0, 3'b111, 16'd0});
        measure(n);
        for (int k = 0; k < 4; k++) begin
            out_dir = k[0];
            out_en  = k[1];
            #1;
            chk(irq_pin == (k == 3) && rd_data[31] == 1'b1, "R8", irq_pin, k == 3);
        end
        measure(n);
        chk(irq_pin == 1'b0 && rd_data[31] == 1'b0, "R8 low", irq_pin, 0);

        // R9: diag bit stored, waveform unchanged
        wr({12'd0, 1'b1, 3'b111, 16'd2});
        chk(rd_data[19] == 1'b1, "R9 readback", rd_data[19], 1);
        measure(n);
        chk(n == 3 * P, "R9 period", n, 3 * P);
        measure(n);
        chk(n == 3 * P, "R9 period", n, 3 * P);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule